// File: doc/BRIEF.md
# I2C Master Interrupt Register Bank

This block holds the interrupt state of an I2C master controller. The transfer logic signals events as single-cycle pulses: completion, data threshold, NACK, timeout, slave ready, receive overflow, transmit overflow, receive underflow and arbitration lost. Each event latches into a sticky status bit. A status bit is cleared by writing 1 to it. A mask register gates which latched events reach the level interrupt output.

Software never modifies the mask in place. It writes 1s to an enable register to clear mask bits and 1s to a disable register to set them. Both of those registers read as zero.

A separate bus-stall timer counts SCL-low periods. It restarts each time the bus makes progress. When the count passes a programmable 8-bit limit, it raises the timeout event internally. The block also drives a flag that is high whenever any latched error-class event is present.

Register word addresses on `regAddr`: 0 status (read / write-1-to-clear), 1 mask (read-only), 2 enable (write-only), 3 disable (write-only), 4 stall limit (read/write). Any other address reads as zero and ignores writes. Reads are combinational from `regAddr`. Writes take effect at the clock edge where `wrEn` is high.

Top module: `i2c_irq_bank`

## Requirements
- R1: All event registers use one bit layout: bit 0 complete, bit 1 data, bit 2 NACK, bit 3 timeout, bit 4 slave ready, bit 5 receive overflow, bit 6 transmit overflow, bit 7 receive underflow, bit 9 arbitration lost. Bit 8 is reserved and always reads 0 in status and mask, even when it is pulsed.
- R2: An event pulse on `evtIn[k]` sets status bit k at the next clock edge, whether or not bit k is masked.
- R3: A write to address 0 clears each status bit written with 1 and leaves the bits written with 0 unchanged. If an event hits the same bit in the same cycle as its clear, the bit stays set. Without a write to address 0, status bits never fall.
- R4: The mask register (address 1) is read-only. A write to address 1 leaves the mask unchanged.
- R5: Writing 1s to address 2 clears those mask bits. Writing 1s to address 3 sets them. Bits written with 0 are untouched in both cases. Reads of addresses 2 and 3 return 0.
- R6: After reset, status is 0x000, mask is 0x2FF (all defined bits set), the stall limit is 0xFF, and `irqOut` and `errOut` are 0.
- R7: `irqOut` is high exactly when some status bit is set and its mask bit is clear.
- R8: Address 4 holds an 8-bit stall limit, written from `wrData[7:0]`. It reads back with bits 9:8 equal to zero.
- R9: The stall counter advances on each `sclLowTick` and clears on `busProgress`; `busProgress` wins if both arrive together. With limit L and no progress, the (L+1)-th tick sets status bit 3 and restarts the count.
- R10: `errOut` is high whenever any of status bits 2, 5, 6, 7 or 9 is set, regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| wrData | input | 10 | Write data |
| rdData | output | 10 | Read data for `regAddr` |
| evtIn | input | 10 | Single-cycle event pulses, one per status bit |
| sclLowTick | input | 1 | One pulse per SCL-low period |
| busProgress | input | 1 | Pulse when the bus advances; restarts the stall counter |
| irqOut | output | 1 | Level interrupt, OR of unmasked status bits |
| errOut | output | 1 | High while any error-class status bit is set |

## Verification
The assertions assume that `evtIn`, `sclLowTick` and `busProgress` are one-cycle pulses sampled at the clock edge. They also assume `wrEn` asserts for one cycle per register access, with `regAddr` and `wrData` stable across that edge. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It reads on the following falling edge, after the result has settled. Same-cycle collisions are created on purpose only where a requirement defines their outcome: a clear meeting an event, and a tick meeting a progress pulse.

// File: rtl/i2c_irq_bank_pkg.sv
package i2c_irq_bank_pkg;
  localparam int EVT_W  = 10;
  localparam int ADDR_W = 3;
  localparam int TMO_W  = 8;
  localparam int TMO_BIT = 3;

  localparam logic [EVT_W-1:0] EVT_VALID = 10'h2FF;
  localparam logic [EVT_W-1:0] ERR_GROUP = 10'h2E4;

  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK    = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DISABLE = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIMIT   = 3'd4;

  typedef struct packed {
    logic clrStatus;
    logic enMask;
    logic disMask;
    logic ldLimit;
    logic tmoEvt;
  } bank_strobe_t;
endpackage

// File: rtl/i2c_irq_bank_ctrl.sv
module i2c_irq_bank_ctrl
  import i2c_irq_bank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int TW = TMO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] regAddr,
  input  logic          sclLowTick,
  input  logic          busProgress,
  input  logic [TW-1:0] limitQ,
  output bank_strobe_t  strb,
  output logic [TW-1:0] tmoCount
);
  logic expire;

  // A tick that finds the count at or above the limit expires the timer.
  assign expire = sclLowTick && !busProgress && (tmoCount >= limitQ);

  always_comb begin
    strb.clrStatus = wrEn && (regAddr == A_STATUS);
    strb.enMask    = wrEn && (regAddr == A_ENABLE);
    strb.disMask   = wrEn && (regAddr == A_DISABLE);
    strb.ldLimit   = wrEn && (regAddr == A_LIMIT);
    strb.tmoEvt    = expire;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            tmoCount <= '0;
    else if (busProgress) tmoCount <= '0;
    else if (expire)      tmoCount <= '0;
    else if (sclLowTick)  tmoCount <= tmoCount + 1'b1;
  end
endmodule

// File: rtl/i2c_irq_bank_dp.sv
module i2c_irq_bank_dp
  import i2c_irq_bank_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int AW = ADDR_W,
  parameter int TW = TMO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  bank_strobe_t  strb,
  input  logic [AW-1:0] regAddr,
  input  logic [EW-1:0] wrData,
  input  logic [EW-1:0] evtIn,
  output logic [EW-1:0] statusQ,
  output logic [EW-1:0] maskQ,
  output logic [TW-1:0] limitQ,
  output logic [EW-1:0] rdData,
  output logic          irqOut,
  output logic          errOut
);
  localparam int PAD_W = EW - TW;

  logic [EW-1:0] clrBits;
  logic [EW-1:0] setBits;

  assign clrBits = strb.clrStatus ? wrData : '0;
  assign setBits = evtIn | (strb.tmoEvt ? EW'(1) << TMO_BIT : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= EVT_VALID;
      limitQ  <= '1;
    end else begin
      statusQ <= ((statusQ & ~clrBits) | setBits) & EVT_VALID;
      if (strb.enMask)       maskQ <= maskQ & ~wrData;
      else if (strb.disMask) maskQ <= (maskQ | wrData) & EVT_VALID;
      if (strb.ldLimit)      limitQ <= wrData[TW-1:0];
    end
  end

  always_comb begin
    case (regAddr)
      A_STATUS: rdData = statusQ;
      A_MASK:   rdData = maskQ;
      A_LIMIT:  rdData = {{PAD_W{1'b0}}, limitQ};
      default:  rdData = '0;
    endcase
  end

  assign irqOut = |(statusQ & ~maskQ);
  assign errOut = |(statusQ & ERR_GROUP);
endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank
  import i2c_irq_bank_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int AW = ADDR_W,
  parameter int TW = TMO_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [EW-1:0] wrData,
  output logic [EW-1:0] rdData,
  input  logic [EW-1:0] evtIn,
  input  logic          sclLowTick,
  input  logic          busProgress,
  output logic          irqOut,
  output logic          errOut
);
  bank_strobe_t  strb;
  logic [TW-1:0] limitQ;
  logic [TW-1:0] tmoCount;
  logic [EW-1:0] statusQ;
  logic [EW-1:0] maskQ;

  i2c_irq_bank_ctrl #(.AW(AW), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .sclLowTick(sclLowTick), .busProgress(busProgress),
    .limitQ(limitQ), .strb(strb), .tmoCount(tmoCount)
  );

  i2c_irq_bank_dp #(.EW(EW), .AW(AW), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .wrData(wrData), .evtIn(evtIn), .statusQ(statusQ), .maskQ(maskQ),
    .limitQ(limitQ), .rdData(rdData), .irqOut(irqOut), .errOut(errOut)
  );
endmodule

// File: rtl/i2c_irq_bank_chk.sv
module i2c_irq_bank_chk
  import i2c_irq_bank_pkg::*;
#(
  parameter int EW = EVT_W,
  parameter int AW = ADDR_W,
  parameter int TW = TMO_W
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] regAddr,
  input logic [EW-1:0] wrData,
  input logic [EW-1:0] evtIn,
  input logic          sclLowTick,
  input logic          busProgress,
  input logic          irqOut,
  input logic [EW-1:0] statusQ,
  input logic [EW-1:0] maskQ,
  input logic [TW-1:0] tmoCount,
  input bank_strobe_t  strb
);
  logic [EW-1:0] tmoVec;
  logic [EW-1:0] evtV;
  logic          wrStatus;
  logic          wrMaskCtl;

  assign tmoVec    = strb.tmoEvt ? (EW'(1) << TMO_BIT) : '0;
  assign evtV      = evtIn & EVT_VALID;
  assign wrStatus  = wrEn && (regAddr == A_STATUS);
  assign wrMaskCtl = wrEn && (regAddr == A_ENABLE || regAddr == A_DISABLE);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ | maskQ) & ~EVT_VALID) == '0);

  assert_event_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtV != '0) |=> ((statusQ & $past(evtV)) == $past(evtV)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrStatus |=> ((statusQ & $past(wrData & ~evtIn & ~tmoVec)) == '0));

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrMaskCtl |=> $stable(maskQ));

  assert_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == A_ENABLE) |=> ((maskQ & $past(wrData)) == '0));

  assert_disable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == A_DISABLE) |=>
      ((maskQ & $past(wrData & EVT_VALID)) == $past(wrData & EVT_VALID)));

  assert_irq_needs_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == EVT_VALID) |-> !irqOut);

  assert_tmo_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.tmoEvt |-> (sclLowTick && !busProgress));

  assert_tmo_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    busProgress |=> (tmoCount == '0));
endmodule

bind i2c_irq_bank i2c_irq_bank_chk #(.EW(EW), .AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .evtIn(evtIn), .sclLowTick(sclLowTick), .busProgress(busProgress),
  .irqOut(irqOut), .statusQ(statusQ), .maskQ(maskQ), .tmoCount(tmoCount),
  .strb(strb)
);

// File: tb/test_i2c_irq_bank.sv
module test_i2c_irq_bank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [9:0] wrData = '0;
  logic [9:0] rdData;
  logic [9:0] evtIn = '0;
  logic       sclLowTick = 1'b0;
  logic       busProgress = 1'b0;
  logic       irqOut;
  logic       errOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  i2c_irq_bank i_i2c_irq_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .sclLowTick(sclLowTick),
    .busProgress(busProgress), .irqOut(irqOut), .errOut(errOut)
  );

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [9:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic pulseEvt(input logic [9:0] e);
    @(negedge clk);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sclLowTick = 1'b1;
      @(negedge clk);
      sclLowTick = 1'b0;
    end
  endtask

  task automatic clearAll();
    writeReg(3'd0, 10'h3FF);
    writeReg(3'd3, 10'h3FF);
  endtask

  task automatic testReset();
    logic [9:0] v;
    readReg(3'd0, v); check("R6 status", v, 10'h000);
    readReg(3'd1, v); check("R6 mask", v, 10'h2FF);
    readReg(3'd4, v); check("R6 limit", v, 10'h0FF);
    check("R6 irq", {9'd0, irqOut}, 10'd0);
    check("R6 err", {9'd0, errOut}, 10'd0);
  endtask

  task automatic testLatch();
    logic [9:0] v;
    pulseEvt(10'h002);
    readReg(3'd0, v); check("R2 masked event latches", v, 10'h002);
    check("R7 masked no irq", {9'd0, irqOut}, 10'd0);
    pulseEvt(10'h3FF);
    readReg(3'd0, v); check("R1 reserved bit8 in status", v, 10'h2FF);
    readReg(3'd1, v); check("R1 reserved bit8 in mask", v, 10'h2FF);
  endtask

  task automatic testClear();
    logic [9:0] v;
    writeReg(3'd0, 10'h0F0);
    readReg(3'd0, v); check("R3 w1c selected bits", v, 10'h20F);
    writeReg(3'd0, 10'h000);
    readReg(3'd0, v); check("R3 zero write no effect", v, 10'h20F);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 3'd0; wrData = 10'h001; evtIn = 10'h001;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evtIn = '0;
    readReg(3'd0, v); check("R3 event beats clear", v, 10'h20F);
    writeReg(3'd0, 10'h3FF);
    readReg(3'd0, v); check("R3 clear all", v, 10'h000);
  endtask

  task automatic testMask();
    logic [9:0] v;
    writeReg(3'd1, 10'h000);
    readReg(3'd1, v); check("R4 mask read-only", v, 10'h2FF);
    pulseEvt(10'h001);
    check("R7 still masked", {9'd0, irqOut}, 10'd0);
    writeReg(3'd2, 10'h005);
    readReg(3'd1, v); check("R5 enable clears bits", v, 10'h2FA);
    check("R7 unmasked status raises irq", {9'd0, irqOut}, 10'd1);
    readReg(3'd2, v); check("R5 enable reads zero", v, 10'h000);
    writeReg(3'd3, 10'h001);
    readReg(3'd1, v); check("R5 disable sets bit", v, 10'h2FB);
    check("R7 remasked irq low", {9'd0, irqOut}, 10'd0);
    readReg(3'd3, v); check("R5 disable reads zero", v, 10'h000);
    pulseEvt(10'h004);
    check("R7 bit2 enabled irq", {9'd0, irqOut}, 10'd1);
    clearAll();
  endtask

  task automatic testErr();
    pulseEvt(10'h001);
    check("R10 complete not error", {9'd0, errOut}, 10'd0);
    pulseEvt(10'h200);
    check("R10 arb lost is error while masked", {9'd0, errOut}, 10'd1);
    clearAll();
    check("R10 cleared", {9'd0, errOut}, 10'd0);
  endtask

  task automatic testLimit();
    logic [9:0] v;
    writeReg(3'd4, 10'h3FF);
    readReg(3'd4, v); check("R8 limit upper bits zero", v, 10'h0FF);
    writeReg(3'd4, 10'h003);
    readReg(3'd4, v); check("R8 limit readback", v, 10'h003);
  endtask

  task automatic testTimeout();
    logic [9:0] v;
    @(negedge clk); busProgress = 1'b1;
    @(negedge clk); busProgress = 1'b0;
    ticks(3);
    readReg(3'd0, v); check("R9 no timeout at limit", v, 10'h000);
    ticks(1);
    readReg(3'd0, v); check("R9 timeout after limit+1 ticks", v, 10'h008);
    writeReg(3'd0, 10'h008);
    ticks(2);
    @(negedge clk); busProgress = 1'b1; sclLowTick = 1'b1;
    @(negedge clk); busProgress = 1'b0; sclLowTick = 1'b0;
    ticks(3);
    readReg(3'd0, v); check("R9 progress restarts count", v, 10'h000);
    ticks(1);
    readReg(3'd0, v); check("R9 timeout after restart", v, 10'h008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatch();
    testClear();
    testMask();
    testErr();
    testLimit();
    testTimeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule